// File: doc/BRIEF.md
# Gated Timer/Counter with Auto-Reload

This block is a byte-organised counter/timer for a microcontroller-class subsystem. Two count registers, a low half and a high half, either chain into one double-width free-running counter or split into a running low half that refills itself from the high half each time it wraps. In the split arrangement the high half keeps its value, so software loads a period once and gets a steady stream of overflows.

The count source is picked in the control register. It can be every system clock, a one-cycle tick from an external prescaler, or falling edges on an asynchronous event pin. Counting only happens while a run bit is set. When the gate mode is chosen, the low level of a gate pin is also required. Every wrap sets a sticky overflow flag, which raises the interrupt line when interrupts are enabled. Software clears the flag by writing the control register.

Software must load the low half before it sets the run bit, so that the first period has the intended length.

Top module: `reload_timer`

## Requirements
- R1: After reset the low half, the high half and every control bit are zero, and `irq` is low.
- R2: With control bit 4 clear, {high, low} counts up by one per qualified tick. A tick at 0xFFFF gives 0x0000, sets the overflow flag, and counting carries on from zero.
- R3: With control bit 4 set, only the low half counts. A tick at all-ones loads the low half with the high half's value and sets the overflow flag.
- R4: With control bit 4 set, counting and reloads never change the high half. Only a register write changes it.
- R5: The overflow flag (control bit 6) stays set until a control write carries 0 in bit 6. A control write in the same cycle as an overflow decides the flag's value.
- R6: `irq` is high exactly when the overflow flag is set and control bit 5 (interrupt enable) is set.
- R7: A tick counts only when control bit 0 (run) is 1 and either control bit 1 (gate mode) is 0 or `gate_n` is low. Otherwise both halves hold.
- R8: With control bit 2 clear, the tick source depends on control bit 3. When bit 3 is 0, every clock is a tick. When bit 3 is 1, a clock is a tick only if `presc_tick` is high in that cycle.
- R9: With control bit 2 set, `evt_in` passes through two synchronizer flops. Each high-to-low change seen at the second flop is one tick.
- R10: A write to the low or high half in a cycle that carries a tick stores the written value. It cancels that cycle's increment and any overflow it would have caused.
- R11: Register map: address 0 is the low half, 1 the high half, 2 the control register (bits 0 to 6, upper bits read 0). Address 3 reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | HALF_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | HALF_W | Register read data, combinational |
| presc_tick | input | 1 | One-cycle prescaled clock enable |
| evt_in | input | 1 | Asynchronous external event input |
| gate_n | input | 1 | External gate, active low |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with HALF_W = 8. With this width the reload wrap at 0xFF comes within a few cycles, and a double-width wrap is reached by preloading 0xFFF0. Every rollover, reload, flag race and write-versus-count collision therefore occurs many times in a short run. The reference model is compared on every cycle against one rotating register read and against `irq`.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [HALF_W-1:0] rd_data,
  input  logic              presc_tick,
  input  logic              evt_in,
  input  logic              gate_n,
  output logic              irq
);
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTL = 2'd2;

  logic [HALF_W-1:0] lo_q, hi_q;
  logic run_q, gate_en_q, evt_mode_q, presc_sel_q, reload_q, ien_q, flag_q;
  logic [2:0] evt_sync;

  wire wr_lo    = wr_en && wr_addr == A_LO;
  wire wr_hi    = wr_en && wr_addr == A_HI;
  wire wr_ctl   = wr_en && wr_addr == A_CTL;
  wire evt_fall = evt_sync[2] & ~evt_sync[1];
  wire tick     = evt_mode_q ? evt_fall : (presc_sel_q ? presc_tick : 1'b1);
  wire cnt_en   = run_q & (~gate_en_q | ~gate_n);
  wire bump     = cnt_en & tick & ~wr_lo & ~wr_hi;
  wire lo_full  = &lo_q;
  wire ovf      = bump & lo_full & (reload_q | (&hi_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_sync <= '0;
    else        evt_sync <= {evt_sync[1:0], evt_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo)     lo_q <= wr_data;
      else if (bump) lo_q <= (reload_q && lo_full) ? hi_q : lo_q + 1'b1;
      if (wr_hi)     hi_q <= wr_data;
      else if (bump && !reload_q && lo_full) hi_q <= hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {flag_q, ien_q, reload_q, presc_sel_q, evt_mode_q, gate_en_q, run_q} <= '0;
    end else if (wr_ctl) begin
      {flag_q, ien_q, reload_q, presc_sel_q, evt_mode_q, gate_en_q, run_q} <= wr_data[6:0];
    end else if (ovf) begin
      flag_q <= 1'b1;
    end
  end

  assign irq = flag_q & ien_q;

  always_comb begin
    case (rd_addr)
      A_LO:    rd_data = lo_q;
      A_HI:    rd_data = hi_q;
      A_CTL:   rd_data = HALF_W'({flag_q, ien_q, reload_q, presc_sel_q, evt_mode_q, gate_en_q, run_q});
      default: rd_data = '0;
    endcase
  end

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q && bump && lo_full) |=> lo_q == $past(hi_q));

  assert_hi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q && !wr_hi) |=> hi_q == $past(hi_q));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wr_ctl) |=> flag_q);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

  assert_wr_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wr_data));
endmodule

// File: tb/sim_reload_timer.sv
module sim_reload_timer;
  localparam int HW = 8;
  localparam int MAXV = (1 << HW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [HW-1:0] wr_data = '0;
  logic [HW-1:0] rd_data;
  logic presc_tick = 1'b0, evt_in = 1'b1, gate_n = 1'b1;
  logic irq;

  int compared = 0, mismatched = 0;
  string req = "R1";
  bit done = 0;

  int m_lo, m_hi, e1, e2, e3;
  bit run, gen, evm, psel, rld, ien, flg;

  reload_timer #(.HALF_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .presc_tick(presc_tick), .evt_in(evt_in),
    .gate_n(gate_n), .irq(irq));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; e1 = 0; e2 = 0; e3 = 0;
      {run, gen, evm, psel, rld, ien, flg} = '0;
    end else begin
      bit fall, t, inc, wl, wh, wc, ov;
      fall = (e3 == 1) && (e2 == 0);
      e3 = e2; e2 = e1; e1 = int'(evt_in);
      t   = evm ? fall : (psel ? presc_tick : 1'b1);
      wl  = wr_en && wr_addr == 2'd0;
      wh  = wr_en && wr_addr == 2'd1;
      wc  = wr_en && wr_addr == 2'd2;
      inc = run && (!gen || !gate_n) && t && !wl && !wh;
      ov  = inc && (rld ? m_lo == MAXV : (m_lo == MAXV && m_hi == MAXV));
      if (inc) begin
        if (rld) m_lo = (m_lo == MAXV) ? m_hi : m_lo + 1;
        else begin
          int v;
          v = ((m_hi << HW) + m_lo + 1) % (1 << (2 * HW));
          m_lo = v & MAXV; m_hi = v >> HW;
        end
      end
      if (wl) m_lo = int'(wr_data);
      if (wh) m_hi = int'(wr_data);
      if (wc) {flg, ien, rld, psel, evm, gen, run} = wr_data[6:0];
      else if (ov) flg = 1'b1;
    end
  end

  task automatic check();
    int exp_rd;
    case (rd_addr)
      2'd0: exp_rd = m_lo;
      2'd1: exp_rd = m_hi;
      2'd2: exp_rd = int'({flg, ien, rld, psel, evm, gen, run});
      default: exp_rd = 0;
    endcase
    compared++;
    if (rd_data !== exp_rd[HW-1:0]) begin
      mismatched++;
      $display("FAIL %s rd_addr=%0d actual=%0h expected=%0h", req, rd_addr, rd_data, exp_rd);
    end
    compared++;
    if (irq !== (flg && ien)) begin
      mismatched++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq, flg && ien);
    end
  endtask

  task automatic step(input bit we = 0, input logic [1:0] a = 0, input int d = 0);
    @(negedge clk);
    if (rst_n) check();
    wr_en = we; wr_addr = a; wr_data = d[HW-1:0];
    rd_addr = rd_addr + 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; idle(4);
    req = "R11"; step(1, 2'd3, 8'hFF); idle(4);
    req = "R2"; step(1, 0, 8'hF0); step(1, 1, 8'hFF); step(1, 2, 8'h01); idle(40);
    req = "R6"; step(1, 2, 8'h61); idle(6);
    req = "R5"; step(1, 2, 8'h21); idle(6);
    req = "R3"; step(1, 1, 8'h80); step(1, 0, 8'hFA); step(1, 2, 8'h31); idle(300);
    req = "R4"; step(1, 2, 8'h31); idle(20);
    req = "R5";
    for (int k = 0; k < 12; k++) begin step(1, 0, 8'hFD); idle(k % 4); step(1, 2, 8'h31); idle(3); end
    req = "R10";
    for (int k = 0; k < 10; k++) begin step(1, 0, 8'hFF); step(1, k % 2, 8'hFF); idle(3); end
    step(1, 2, 8'h01); step(1, 0, 8'hFF); step(1, 1, 8'hFF); step(1, 0, 8'hFE); idle(4);
    req = "R7"; step(1, 2, 8'h33);
    for (int i = 0; i < 200; i++) begin gate_n = (i % 7) < 3; step(); end
    step(1, 2, 8'h30); idle(10); gate_n = 1'b1;
    req = "R8"; step(1, 2, 8'h39);
    for (int i = 0; i < 300; i++) begin presc_tick = ($urandom % 3) == 0; step(); end
    presc_tick = 1'b0;
    req = "R9"; step(1, 2, 8'h35);
    for (int i = 0; i < 600; i++) begin evt_in = ($urandom % 4) != 0; step(); end
    evt_in = 1'b1; idle(5);
    req = "R2"; step(1, 2, 8'h21);
    for (int i = 0; i < 2000; i++) begin
      if ($urandom % 50 == 0) step(1, 2'($urandom % 4), int'($urandom % 256) & 8'h2F | 8'h01);
      else step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule